// File: doc/BRIEF.md
# PCIe Port Link Capability and Status Clamp

This block produces the link-related register images of a PCIe port: the link capability word, the link capability 2 word, the link status word and the target-speed field of link control 2. The capability images are derived from a configured maximum link width and maximum speed code, together with a port number. Several capability bits follow from those two settings.

The block also keeps the port's reported negotiated width and current speed in step with the device behind the port. On each sync strobe it takes the downstream device's raw link status word and does not trust it. A width or speed above the port's own maximum is reported as that maximum. A zero field is replaced by the minimum value. When no device is present, the capability values are mirrored instead.

An outside register front end owns configuration decoding and reads these images. All outputs are registered and change only on the clock edge that samples the strobe.

Top module: `pcie_link_clamp`

## Requirements
- R1: After reset, linkCap reads 0x00000011 (speed code 1, width 1, port 0, ASPM support 0), linkCap2 reads 0, linkStatus reads 0x0011 and linkTgtSpeed reads 0.
- R2: On the clock edge that samples syncStb high, linkCap takes maxSpeed in bits 3:0, maxWidth in bits 9:4, portNum in bits 31:24, and zero in the ASPM support bits 11:10. Speed codes are 1 = 2.5 GT/s, 2 = 5 GT/s, 3 = 8 GT/s and 4 = 16 GT/s, and the same codes are used in linkStatus.
- R3: linkCap bit 21 (bandwidth notification capable) is 1 exactly when maxWidth > 1 or maxSpeed > 1.
- R4: When maxSpeed > 1, linkCap bit 20 (link-active reporting capable) is 1, linkStatus bit 13 (link active) is 1 and linkTgtSpeed equals maxSpeed. Otherwise all three are 0.
- R5: linkCap2 is 0 unless maxSpeed > 2. Then bits 1, 2 and 3 are set (2.5, 5 and 8 GT/s), bit 4 (16 GT/s) is also set when maxSpeed > 3, and every other bit is 0.
- R6: On a sync with devPresent low, linkStatus bits 3:0 and 9:4 take the maxSpeed and maxWidth values.
- R7: On a sync with devPresent high, the reported width is taken from devLinkStatus bits 9:4. A value of 0 is reported as 1, and a value above maxWidth is reported as maxWidth.
- R8: On a sync with devPresent high, the reported speed is taken from devLinkStatus bits 3:0. A value of 0 is reported as 1, and a value above maxSpeed is reported as maxSpeed.
- R9: Bits 15:14 and 12:10 of devLinkStatus are ignored. Those bits of linkStatus are always 0, and a sync changes only the speed and width fields plus the link-active bit of R4.
- R10: While syncStb is low, all four outputs hold their values, even when the configuration or downstream inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| maxWidth | input | 6 | Configured maximum link width |
| maxSpeed | input | 4 | Configured maximum speed code (1..4) |
| portNum | input | 8 | Port number placed in the capability word |
| devPresent | input | 1 | A downstream device is present |
| devLinkStatus | input | 16 | Raw link status word of the downstream device |
| syncStb | input | 1 | Update strobe |
| linkCap | output | 32 | Link capability image |
| linkCap2 | output | 32 | Link capability 2 image |
| linkStatus | output | 16 | Link status image |
| linkTgtSpeed | output | 4 | Target link speed field of link control 2 |

## Verification
Every maximum speed code is paired with the power-of-two widths from x1 to x16. First, a sync with no device present shows the mirrored status and all the capability bits that depend on speed and width. For each setting, downstream speed codes 0 to 5 are crossed with widths 0, 1, 2, 4, 8, 16, 32 and 63, with noise in the status bits that must be ignored. These patterns separate the zero substitution from the clamp to the maximum and from plain pass-through. A final phase changes every input with the strobe low, to show that the outputs hold.

// File: rtl/pcie_link_clamp_pkg.sv
package pcie_link_clamp_pkg;
  localparam int SPEED_BITS = 4;
  localparam int WIDTH_BITS = 6;
  localparam int PORT_BITS  = 8;
  localparam int SPD_LSB    = 0;
  localparam int WID_LSB    = 4;
  localparam int PORT_LSB   = 24;
  localparam int CAP_DLLARC = 20;
  localparam int CAP_BWNOT  = 21;
  localparam int STA_ACTIVE = 13;

  typedef struct packed {
    logic load;
    logic useDev;
  } clampCtl_t;
endpackage

// File: rtl/pcie_link_clamp_ctrl.sv
module pcie_link_clamp_ctrl
  import pcie_link_clamp_pkg::*;
(
  input  logic      syncStb,
  input  logic      devPresent,
  output clampCtl_t ctl
);
  always_comb begin
    ctl.load   = syncStb;
    ctl.useDev = syncStb & devPresent;
  end
endmodule

// File: rtl/pcie_link_clamp_dp.sv
module pcie_link_clamp_dp
  import pcie_link_clamp_pkg::*;
#(
  parameter int MAX_SPEED_CODE = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  clampCtl_t             ctl,
  input  logic [WIDTH_BITS-1:0] maxWidth,
  input  logic [SPEED_BITS-1:0] maxSpeed,
  input  logic [PORT_BITS-1:0]  portNum,
  input  logic [15:0]           devLinkStatus,
  output logic [31:0]           linkCap,
  output logic [31:0]           linkCap2,
  output logic [15:0]           linkStatus,
  output logic [SPEED_BITS-1:0] linkTgtSpeed
);
  localparam logic [SPEED_BITS-1:0] SPD_MIN = SPEED_BITS'(1);
  localparam logic [WIDTH_BITS-1:0] WID_MIN = WIDTH_BITS'(1);

  logic [SPEED_BITS-1:0] devSpd, spdNext;
  logic [WIDTH_BITS-1:0] devWid, widNext;
  logic [31:0] capNext, cap2Next;
  logic [15:0] staNext;
  logic        fastLink;

  assign devSpd   = devLinkStatus[SPD_LSB +: SPEED_BITS];
  assign devWid   = devLinkStatus[WID_LSB +: WIDTH_BITS];
  assign fastLink = maxSpeed > SPD_MIN;

  always_comb begin
    if (!ctl.useDev)             spdNext = maxSpeed;
    else if (devSpd == '0)       spdNext = SPD_MIN;
    else if (devSpd > maxSpeed)  spdNext = maxSpeed;
    else                         spdNext = devSpd;

    if (!ctl.useDev)             widNext = maxWidth;
    else if (devWid == '0)       widNext = WID_MIN;
    else if (devWid > maxWidth)  widNext = maxWidth;
    else                         widNext = devWid;
  end

  always_comb begin
    capNext = '0;
    capNext[SPD_LSB +: SPEED_BITS]  = maxSpeed;
    capNext[WID_LSB +: WIDTH_BITS]  = maxWidth;
    capNext[PORT_LSB +: PORT_BITS]  = portNum;
    capNext[CAP_DLLARC]             = fastLink;
    capNext[CAP_BWNOT]              = fastLink | (maxWidth > WID_MIN);

    staNext = '0;
    staNext[SPD_LSB +: SPEED_BITS]  = spdNext;
    staNext[WID_LSB +: WIDTH_BITS]  = widNext;
    staNext[STA_ACTIVE]             = fastLink;
  end

  // Supported-speed vector: one bit per speed code, only above 5 GT/s
  always_comb begin
    cap2Next = '0;
    for (int i = 1; i <= MAX_SPEED_CODE; i++) begin
      cap2Next[i] = (maxSpeed > SPEED_BITS'(2)) &&
                    ((i < 3) || (SPEED_BITS'(i) <= maxSpeed));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      linkCap      <= 32'h0000_0011;
      linkCap2     <= '0;
      linkStatus   <= 16'h0011;
      linkTgtSpeed <= '0;
    end else if (ctl.load) begin
      linkCap      <= capNext;
      linkCap2     <= cap2Next;
      linkStatus   <= staNext;
      linkTgtSpeed <= fastLink ? maxSpeed : '0;
    end
  end
endmodule

// File: rtl/pcie_link_clamp.sv
module pcie_link_clamp
  import pcie_link_clamp_pkg::*;
#(
  parameter int MAX_SPEED_CODE = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [5:0]  maxWidth,
  input  logic [3:0]  maxSpeed,
  input  logic [7:0]  portNum,
  input  logic        devPresent,
  input  logic [15:0] devLinkStatus,
  input  logic        syncStb,
  output logic [31:0] linkCap,
  output logic [31:0] linkCap2,
  output logic [15:0] linkStatus,
  output logic [3:0]  linkTgtSpeed
);
  clampCtl_t ctl;

  pcie_link_clamp_ctrl u_ctrl (
    .syncStb    (syncStb),
    .devPresent (devPresent),
    .ctl        (ctl)
  );

  pcie_link_clamp_dp #(.MAX_SPEED_CODE(MAX_SPEED_CODE)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .ctl           (ctl),
    .maxWidth      (maxWidth),
    .maxSpeed      (maxSpeed),
    .portNum       (portNum),
    .devLinkStatus (devLinkStatus),
    .linkCap       (linkCap),
    .linkCap2      (linkCap2),
    .linkStatus    (linkStatus),
    .linkTgtSpeed  (linkTgtSpeed)
  );
endmodule

// File: rtl/pcie_link_clamp_chk.sv
module pcie_link_clamp_chk (
  input logic        clk,
  input logic        rstN,
  input logic        syncStb,
  input logic [31:0] linkCap,
  input logic [31:0] linkCap2,
  input logic [15:0] linkStatus,
  input logic [3:0]  linkTgtSpeed
);
  AST_HOLD_NO_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    !syncStb |=> $stable(linkCap) && $stable(linkCap2) && $stable(linkStatus)
                 && $stable(linkTgtSpeed)); // R10
  AST_WIDTH_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (linkStatus[9:4] != 6'd0) && (linkStatus[9:4] <= linkCap[9:4])); // R7
  AST_SPEED_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (linkStatus[3:0] != 4'd0) && (linkStatus[3:0] <= linkCap[3:0])); // R8
  AST_ACTIVE_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    linkCap[20] == linkStatus[13]); // R4
  AST_CAP2_NEEDS_FAST: assert property (@(posedge clk) disable iff (!rstN)
    (linkCap2 != 32'd0) |-> (linkCap[3:0] > 4'd2)); // R5
  AST_STATUS_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (linkStatus[15:14] == 2'd0) && (linkStatus[12:10] == 3'd0)); // R9
endmodule

bind pcie_link_clamp pcie_link_clamp_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .syncStb      (syncStb),
  .linkCap      (linkCap),
  .linkCap2     (linkCap2),
  .linkStatus   (linkStatus),
  .linkTgtSpeed (linkTgtSpeed)
);

// File: tb/pcie_link_clamp_tb.sv
module pcie_link_clamp_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  maxWidth = 6'd1;
  logic [3:0]  maxSpeed = 4'd1;
  logic [7:0]  portNum = 8'd0;
  logic        devPresent = 1'b0;
  logic [15:0] devLinkStatus = 16'd0;
  logic        syncStb = 1'b0;
  logic [31:0] linkCap, linkCap2;
  logic [15:0] linkStatus;
  logic [3:0]  linkTgtSpeed;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pcie_link_clamp u_dut (
    .clk(clk), .rstN(rstN), .maxWidth(maxWidth), .maxSpeed(maxSpeed),
    .portNum(portNum), .devPresent(devPresent), .devLinkStatus(devLinkStatus),
    .syncStb(syncStb), .linkCap(linkCap), .linkCap2(linkCap2),
    .linkStatus(linkStatus), .linkTgtSpeed(linkTgtSpeed)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doSync();
    @(negedge clk) syncStb = 1'b1;
    @(negedge clk) syncStb = 1'b0;
  endtask

  function automatic logic [31:0] expCap(int s, int w, int p);
    logic [31:0] e;
    e = 32'(s) | (32'(w) << 4) | (32'(p) << 24);
    if (s > 1) e[20] = 1'b1;
    if (s > 1 || w > 1) e[21] = 1'b1;
    return e;
  endfunction

  function automatic logic [31:0] expCap2(int s);
    if (s <= 2) return 32'd0;
    return (s > 3) ? 32'h1E : 32'h0E;
  endfunction

  function automatic logic [15:0] expSta(int s, int w, int maxS);
    logic [15:0] e;
    e = 16'(s) | (16'(w) << 4);
    if (maxS > 1) e[13] = 1'b1;
    return e;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=expired expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 cap", linkCap, 32'h0000_0011);
    check("R1 cap2", linkCap2, 32'd0);
    check("R1 status", {16'd0, linkStatus}, 32'h0011);
    check("R1 tgt", {28'd0, linkTgtSpeed}, 32'd0);
    rstN = 1'b1;

    for (int s = 1; s <= 4; s++) begin
      for (int wi = 0; wi <= 4; wi++) begin
        int w;
        w = 1 << wi;
        @(negedge clk);
        maxSpeed = 4'(s);
        maxWidth = 6'(w);
        portNum = 8'(s * 16 + wi);
        devPresent = 1'b0;
        devLinkStatus = 16'hFFFF;
        doSync();
        // R2 R3 R4: capability word
        check("R2 R3 R4 cap", linkCap, expCap(s, w, s * 16 + wi));
        check("R5 cap2", linkCap2, expCap2(s));
        check("R4 tgt", {28'd0, linkTgtSpeed}, (s > 1) ? 32'(s) : 32'd0);
        check("R6 mirror", {16'd0, linkStatus}, {16'd0, expSta(s, w, s)});
        devPresent = 1'b1;
        for (int ds = 0; ds <= 5; ds++) begin
          for (int k = 0; k <= 7; k++) begin
            int dw, es, ew;
            dw = (k == 0) ? 0 : (k == 7) ? 63 : (1 << (k - 1));
            es = (ds == 0) ? 1 : (ds > s) ? s : ds;
            ew = (dw == 0) ? 1 : (dw > w) ? w : dw;
            devLinkStatus = 16'hDC00 | 16'(dw << 4) | 16'(ds);
            doSync();
            // R7 R8 R9: clamped status, noise bits ignored
            check("R7 R8 R9 status", {16'd0, linkStatus}, {16'd0, expSta(es, ew, s)});
          end
        end
      end
    end

    // R10: inputs change with strobe low; outputs hold
    @(negedge clk);
    maxSpeed = 4'd1; maxWidth = 6'd1; portNum = 8'hA5;
    devPresent = 1'b0; devLinkStatus = 16'h0000;
    repeat (3) @(negedge clk);
    check("R10 cap hold", linkCap, expCap(4, 16, 4 * 16 + 4));
    check("R10 cap2 hold", linkCap2, 32'h1E);
    check("R10 status hold", {16'd0, linkStatus}, {16'd0, expSta(4, 16, 4)});
    check("R10 tgt hold", {28'd0, linkTgtSpeed}, 32'd4);
    doSync();
    check("R2 R3 after reload", linkCap, 32'hA500_0011);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule